// File: doc/BRIEF.md
# Three-Source Multiply-Accumulate Execution Unit

An integer execution unit for a 64-bit core that runs the three-operand multiply group: multiply-add and multiply-subtract at 32 and 64 bits, signed and unsigned widening multiply-add and multiply-subtract, and signed and unsigned multiply-high. Each instruction arrives as a 32-bit word together with three operand values that have already been read from the register file: the multiplicand, the multiplier and the addend. The unit returns a 64-bit result, the destination index, a write enable and an illegal-encoding flag.

The unit takes one instruction at a time through a valid/ready handshake. It builds the 128-bit product from four 32x32 partial products, one per cycle. It then presents the result and holds it until the consumer takes it.

Top module: `mac3_unit`

## Requirements
- R1: The opcode is {instr[31], instr[30:29], instr[23:21], instr[15]}, which is 7 bits. The allocated values are 0x00, 0x01, 0x40, 0x41, 0x42, 0x43, 0x44, 0x4A, 0x4B and 0x4C, and instr[28:24] must equal 5'b11011. Any other word gives illegal_o=1, wr_en_o=0 and result_o=0.
- R2: Opcodes 0x40 and 0x41 give addend + a*b and addend - a*b modulo 2^64, using full 64-bit operands. Opcode bit 0 selects subtract.
- R3: Opcodes 0x00 and 0x01 compute the same 64-bit value as R2 and then clear result_o[63:32].
- R4: Opcodes 0x42 and 0x43 sign-extend the low 32 bits of both multiply operands to 64 bits before the multiply-add or multiply-subtract.
- R5: Opcodes 0x4A and 0x4B zero-extend the low 32 bits of both multiply operands to 64 bits before the multiply-add or multiply-subtract.
- R6: Opcode 0x44 returns bits 127:64 of the signed 128-bit product of the two 64-bit operands. Opcode 0x4C returns the same bits of the unsigned product. The addend has no effect on either.
- R7: A source index of 31 reads as zero. The multiplicand index is instr[9:5], the addend index is instr[14:10] and the multiplier index is instr[20:16].
- R8: rd_o carries instr[4:0]. wr_en_o is 1 only for a legal instruction whose destination index is not 31.
- R9: out_valid_o rises exactly 4 clock edges after the edge that accepts an instruction. in_ready_o stays low from acceptance until the result is consumed.
- R10: While out_valid_o=1 and out_ready_i=0, result_o, rd_o, wr_en_o and illegal_o hold steady. out_valid_o falls after the edge that sees out_ready_i=1, so each instruction yields exactly one result.
- R11: After reset, in_ready_o=1 and out_valid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Unit can accept an instruction |
| instr_i | input | 32 | Instruction word |
| src_n_i | input | 64 | Multiplicand value |
| src_m_i | input | 64 | Multiplier value |
| src_a_i | input | 64 | Addend value |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 64 | Result value |
| rd_o | output | 5 | Destination index |
| wr_en_o | output | 1 | Result is to be written |
| illegal_o | output | 1 | Unallocated encoding |

## Verification
Every result, legal or illegal, is due 4 clock edges after the accepting edge. The bench drives on the falling edge and counts rising edges between acceptance and the first falling-edge sample that shows out_valid_o. That count must be exactly 4, and only then does the bench compare the result with a 128-bit reference model. In the back-pressure case the bench holds out_ready_i low for several cycles and samples the outputs on each falling edge. After the consuming edge it checks that out_valid_o has dropped and in_ready_o has returned.

// File: rtl/mac3_pkg.sv
package mac3_pkg;
  localparam int XLEN  = 64;
  localparam int IDX_W = 5;
  localparam int OPC_W = 7;

  typedef struct packed {
    logic legal;
    logic sf;
    logic sub;
    logic high;
    logic widen;
    logic sgn;
  } op_ctl_t;

  function automatic logic opc_alloc(input logic [OPC_W-1:0] opc);
    case (opc)
      7'h00, 7'h01, 7'h40, 7'h41, 7'h42, 7'h43, 7'h44,
      7'h4A, 7'h4B, 7'h4C: opc_alloc = 1'b1;
      default:             opc_alloc = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mac3_decode.sv
module mac3_decode
  import mac3_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int IW    = IDX_W
) (
  input  logic [31:0]   instr_i,
  input  logic [W-1:0]  src_n_i,
  input  logic [W-1:0]  src_m_i,
  input  logic [W-1:0]  src_a_i,
  output op_ctl_t       ctl_o,
  output logic [W-1:0]  mul_a_o,
  output logic [W-1:0]  mul_b_o,
  output logic [W-1:0]  add_c_o,
  output logic [IW-1:0] rd_o
);
  localparam int HALF = W / 2;
  localparam logic [IW-1:0] ZREG = '1;

  logic [OPC_W-1:0] opc;
  logic [IW-1:0]    idx_n, idx_m, idx_a;
  logic [W-1:0]     n_val, m_val;

  assign opc   = {instr_i[31], instr_i[30:29], instr_i[23:21], instr_i[15]};
  assign idx_n = instr_i[9:5];
  assign idx_a = instr_i[14:10];
  assign idx_m = instr_i[20:16];
  assign rd_o  = instr_i[4:0];

  always_comb begin
    ctl_o.legal = opc_alloc(opc) && (instr_i[28:24] == 5'b11011);
    ctl_o.sf    = opc[6];
    ctl_o.sub   = opc[0];
    ctl_o.high  = opc[2];
    ctl_o.widen = opc[6] && (opc[3:1] != 3'b000) && !opc[2];
    ctl_o.sgn   = opc[6] && !opc[3] && (opc[2:1] != 2'b00);
  end

  // zero register on every source
  assign n_val   = (idx_n == ZREG) ? '0 : src_n_i;
  assign m_val   = (idx_m == ZREG) ? '0 : src_m_i;
  assign add_c_o = (idx_a == ZREG) ? '0 : src_a_i;

  always_comb begin
    if (ctl_o.widen && ctl_o.sgn) begin
      mul_a_o = {{HALF{n_val[HALF-1]}}, n_val[HALF-1:0]};
      mul_b_o = {{HALF{m_val[HALF-1]}}, m_val[HALF-1:0]};
    end else if (ctl_o.widen) begin
      mul_a_o = {{HALF{1'b0}}, n_val[HALF-1:0]};
      mul_b_o = {{HALF{1'b0}}, m_val[HALF-1:0]};
    end else begin
      mul_a_o = n_val;
      mul_b_o = m_val;
    end
  end
endmodule

// File: rtl/mac3_mul.sv
module mac3_mul #(
  parameter int W = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o,
  output logic           last_o
);
  localparam int HALF = W / 2;
  localparam int PW   = 2 * W;
  localparam int NSTEP = 4;
  localparam int CW   = $clog2(NSTEP);

  logic [CW-1:0]     cnt_q;
  logic              busy_q;
  logic [PW-1:0]     acc_q;
  logic [HALF-1:0]   a_half, b_half;
  logic [W-1:0]      pp;
  logic [PW-1:0]     pp_sh;
  logic [CW:0]       sh_units;

  // step k: a half = k[1], b half = k[0]
  assign a_half   = cnt_q[1] ? a_i[W-1:HALF] : a_i[HALF-1:0];
  assign b_half   = cnt_q[0] ? b_i[W-1:HALF] : b_i[HALF-1:0];
  assign pp       = W'(a_half) * W'(b_half);
  assign sh_units = (CW+1)'(cnt_q[0]) + (CW+1)'(cnt_q[1]);
  assign pp_sh    = PW'(pp) << (sh_units * HALF);
  assign last_o   = busy_q && (cnt_q == CW'(NSTEP-1));
  assign prod_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      acc_q  <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      acc_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_q + pp_sh;
      cnt_q <= cnt_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mac3_unit.sv
module mac3_unit
  import mac3_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] src_n_i,
  input  logic [XLEN-1:0] src_m_i,
  input  logic [XLEN-1:0] src_a_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] result_o,
  output logic [IDX_W-1:0] rd_o,
  output logic            wr_en_o,
  output logic            illegal_o
);
  localparam int HW = XLEN / 2;
  localparam logic [IDX_W-1:0] ZREG = '1;

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_OUT} state_e;

  state_e           state_q;
  op_ctl_t          dec_ctl, ctl_q;
  logic [XLEN-1:0]  dec_a, dec_b, dec_c;
  logic [XLEN-1:0]  a_q, b_q, c_q;
  logic [IDX_W-1:0] dec_rd, rd_q;
  logic             accept, mul_last;
  logic [2*XLEN-1:0] prod;
  logic [XLEN-1:0]  hi_u, hi_fix, lo, sum, res;

  mac3_decode #(.W(XLEN), .IW(IDX_W)) u_dec (
    .instr_i (instr_i),
    .src_n_i (src_n_i),
    .src_m_i (src_m_i),
    .src_a_i (src_a_i),
    .ctl_o   (dec_ctl),
    .mul_a_o (dec_a),
    .mul_b_o (dec_b),
    .add_c_o (dec_c),
    .rd_o    (dec_rd)
  );

  mac3_mul #(.W(XLEN)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .a_i     (a_q),
    .b_i     (b_q),
    .prod_o  (prod),
    .last_o  (mul_last)
  );

  assign in_ready_o  = (state_q == S_IDLE);
  assign out_valid_o = (state_q == S_OUT);
  assign accept      = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ctl_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      rd_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_MUL;
          ctl_q   <= dec_ctl;
          a_q     <= dec_a;
          b_q     <= dec_b;
          c_q     <= dec_c;
          rd_q    <= dec_rd;
        end
        S_MUL:   if (mul_last) state_q <= S_OUT;
        S_OUT:   if (out_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // signed upper half from the unsigned product: subtract the cross terms
  assign hi_u   = prod[2*XLEN-1:XLEN];
  assign hi_fix = hi_u - (a_q[XLEN-1] ? b_q : '0) - (b_q[XLEN-1] ? a_q : '0);
  assign lo     = prod[XLEN-1:0];
  assign sum    = ctl_q.sub ? (c_q - lo) : (c_q + lo);

  always_comb begin
    res = ctl_q.high ? (ctl_q.sgn ? hi_fix : hi_u) : sum;
    if (!ctl_q.sf) res[XLEN-1:HW] = '0;
    if (!ctl_q.legal) res = '0;
  end

  assign result_o  = res;
  assign rd_o      = rd_q;
  assign illegal_o = !ctl_q.legal;
  assign wr_en_o   = ctl_q.legal && (rd_q != ZREG);
endmodule

// File: rtl/mac3_unit_chk.sv
module mac3_unit_chk #(
  parameter int W  = 64,
  parameter int IW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [W-1:0]  result_o,
  input logic [IW-1:0] rd_o,
  input logic          wr_en_o,
  input logic          illegal_o,
  input logic          sf_i
);
  logic [3:0] lat_q;
  logic       run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      run_q <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      lat_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && !out_valid_o && lat_q != 4'hF) begin
      lat_q <= lat_q + 1'b1;
    end else if (out_valid_o && out_ready_i) begin
      run_q <= 1'b0;
    end
  end

  p_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (run_q && lat_q == 4'd4));

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(result_o) && $stable(rd_o) &&
       $stable(wr_en_o) && $stable(illegal_o)));

  p_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> !out_valid_o);

  p_illegal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && illegal_o) |-> (!wr_en_o && result_o == '0));

  p_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !sf_i) |-> (result_o[W-1:W/2] == '0));

  p_zdst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && rd_o == '1) |-> !wr_en_o);
endmodule

bind mac3_unit mac3_unit_chk #(.W(mac3_pkg::XLEN), .IW(mac3_pkg::IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .result_o    (result_o),
  .rd_o        (rd_o),
  .wr_en_o     (wr_en_o),
  .illegal_o   (illegal_o),
  .sf_i        (ctl_q.sf)
);

// File: tb/mac3_unit_tb_top.sv
module mac3_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] instr_i = '0;
  logic [63:0] src_n_i = '0, src_m_i = '0, src_a_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [63:0] result_o;
  logic [4:0]  rd_o;
  logic        wr_en_o, illegal_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mac3_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .instr_i(instr_i),
    .src_n_i(src_n_i), .src_m_i(src_m_i), .src_a_i(src_a_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .result_o(result_o), .rd_o(rd_o), .wr_en_o(wr_en_o), .illegal_o(illegal_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] opc, input logic [4:0] rd,
                                     input logic [4:0] rn, input logic [4:0] ra,
                                     input logic [4:0] rm);
    logic [31:0] w;
    w = '0;
    w[31] = opc[6]; w[30:29] = opc[5:4]; w[28:24] = 5'b11011;
    w[23:21] = opc[3:1]; w[15] = opc[0];
    w[4:0] = rd; w[9:5] = rn; w[14:10] = ra; w[20:16] = rm;
    return w;
  endfunction

  // reference model from the requirements, 128-bit arithmetic
  task automatic model(input logic [31:0] ins, input logic [63:0] n, input logic [63:0] m,
                       input logic [63:0] a, output logic [63:0] res,
                       output logic ill, output logic wen);
    logic [6:0] opc;
    logic [63:0] x, y, z, lo, r;
    logic [127:0] p;
    bit ok, sgn, wid, hi;
    opc = {ins[31], ins[30:29], ins[23:21], ins[15]};
    ok  = (ins[28:24] == 5'b11011) &&
          (opc inside {7'h00, 7'h01, 7'h40, 7'h41, 7'h42, 7'h43, 7'h44,
                       7'h4A, 7'h4B, 7'h4C});
    x = (ins[9:5] == 5'd31) ? 64'd0 : n;
    y = (ins[20:16] == 5'd31) ? 64'd0 : m;
    z = (ins[14:10] == 5'd31) ? 64'd0 : a;
    sgn = opc inside {7'h42, 7'h43, 7'h44};
    wid = opc inside {7'h42, 7'h43, 7'h4A, 7'h4B};
    hi  = opc inside {7'h44, 7'h4C};
    if (wid) begin
      x = sgn ? {{32{x[31]}}, x[31:0]} : {32'd0, x[31:0]};
      y = sgn ? {{32{y[31]}}, y[31:0]} : {32'd0, y[31:0]};
    end
    if (sgn) p = $signed({{64{x[63]}}, x}) * $signed({{64{y[63]}}, y});
    else     p = {64'd0, x} * {64'd0, y};
    lo = p[63:0];
    if (hi) r = p[127:64];
    else    r = opc[0] ? z - lo : z + lo;
    if (!opc[6]) r[63:32] = '0;
    if (!ok) r = '0;
    res = r;
    ill = !ok;
    wen = ok && (ins[4:0] != 5'd31);
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [63:0] n, input logic [63:0] m,
                        input logic [63:0] a, input int hold, input string req);
    logic [63:0] er;
    logic el, ew;
    int lat;
    model(ins, n, m, a, er, el, ew);
    @(negedge clk);
    check(in_ready_o === 1'b1, {req, " R9 ready before issue"}, 64'(in_ready_o), 64'd1);
    instr_i = ins; src_n_i = n; src_m_i = m; src_a_i = a; in_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0; instr_i = '0; src_n_i = '1; src_m_i = '1; src_a_i = '1;
    lat = 0;
    while (!out_valid_o && lat < 20) begin
      check(in_ready_o === 1'b0, {req, " R9 busy"}, 64'(in_ready_o), 64'd0);
      @(posedge clk); @(negedge clk); lat++;
    end
    check(lat == 4, {req, " R9 latency"}, 64'(lat), 64'd4);
    check(result_o === er, {req, " result"}, result_o, er);
    check(illegal_o === el, {req, " R1 illegal flag"}, 64'(illegal_o), 64'(el));
    check(wr_en_o === ew, {req, " R8 write enable"}, 64'(wr_en_o), 64'(ew));
    check(rd_o === ins[4:0], {req, " R8 rd"}, 64'(rd_o), 64'(ins[4:0]));
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); @(negedge clk);
      check(out_valid_o === 1'b1 && result_o === er && rd_o === ins[4:0],
            {req, " R10 hold"}, result_o, er);
    end
    out_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready_i = 1'b0;
    check(out_valid_o === 1'b0, {req, " R10 single result"}, 64'(out_valid_o), 64'd0);
    check(in_ready_o === 1'b1, {req, " R9 ready after consume"}, 64'(in_ready_o), 64'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(in_ready_o === 1'b1, "R11 in_ready", 64'(in_ready_o), 64'd1);
    check(out_valid_o === 1'b0, "R11 out_valid", 64'(out_valid_o), 64'd0);
  endtask

  task automatic t_madd64;
    run_op(mk(7'h40, 5'd3, 5'd1, 5'd2, 5'd4), 64'h1234_5678_9ABC_DEF0,
           64'h0FED_CBA9_8765_4321, 64'h1111_2222_3333_4444, 0, "R2 madd64");
    run_op(mk(7'h41, 5'd7, 5'd1, 5'd2, 5'd4), 64'd7, 64'd9, 64'd5, 0, "R2 msub64 wrap");
    run_op(mk(7'h40, 5'd0, 5'd1, 5'd2, 5'd4), '1, '1, 64'd0, 0, "R2 madd64 all ones");
  endtask

  task automatic t_32bit;
    run_op(mk(7'h00, 5'd1, 5'd2, 5'd3, 5'd4), 64'hFFFF_0000_0001_0003,
           64'h0000_0001_0000_0005, 64'hAAAA_BBBB_CCCC_DDDD, 0, "R3 madd32");
    run_op(mk(7'h01, 5'd1, 5'd2, 5'd3, 5'd4), 64'd3, 64'd4, 64'd1, 0, "R3 msub32");
  endtask

  task automatic t_widen;
    run_op(mk(7'h42, 5'd5, 5'd2, 5'd3, 5'd4), 64'h1234_5678_8000_0000,
           64'hDEAD_BEEF_FFFF_FFFF, 64'd10, 0, "R4 smaddl");
    run_op(mk(7'h43, 5'd5, 5'd2, 5'd3, 5'd4), 64'h0000_0000_8000_0000,
           64'h0000_0000_8000_0000, 64'd0, 0, "R4 smsubl min");
    run_op(mk(7'h4A, 5'd5, 5'd2, 5'd3, 5'd4), 64'hFFFF_FFFF_FFFF_FFFF,
           64'h1234_5678_FFFF_FFFF, 64'd1, 0, "R5 umaddl");
    run_op(mk(7'h4B, 5'd5, 5'd2, 5'd3, 5'd4), 64'h0000_0000_8000_0001,
           64'h0000_0000_0000_0003, 64'd2, 0, "R5 umsubl");
  endtask

  task automatic t_high;
    run_op(mk(7'h44, 5'd6, 5'd2, 5'd3, 5'd4), 64'h8000_0000_0000_0000,
           64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6 smulh min");
    run_op(mk(7'h44, 5'd6, 5'd2, 5'd3, 5'd4), 64'hFFFF_FFFF_FFFF_FFFF,
           64'h0000_0000_0000_0005, 64'h1234, 0, "R6 smulh neg");
    run_op(mk(7'h4C, 5'd6, 5'd2, 5'd3, 5'd4), '1, '1, 64'h5555, 0, "R6 umulh ones");
    run_op(mk(7'h4C, 5'd6, 5'd2, 5'd3, 5'd4), 64'h8000_0000_0000_0000,
           64'd3, 64'd0, 0, "R6 umulh");
  endtask

  task automatic t_zero_reg;
    run_op(mk(7'h40, 5'd1, 5'd31, 5'd2, 5'd3), 64'd99, 64'd7, 64'd5, 0, "R7 rn zero");
    run_op(mk(7'h41, 5'd1, 5'd2, 5'd31, 5'd3), 64'd6, 64'd7, 64'd500, 0, "R7 ra zero");
    run_op(mk(7'h44, 5'd1, 5'd2, 5'd3, 5'd31), '1, '1, 64'd0, 0, "R7 rm zero");
    run_op(mk(7'h40, 5'd31, 5'd2, 5'd3, 5'd4), 64'd2, 64'd3, 64'd4, 0, "R8 rd zero");
  endtask

  task automatic t_illegal;
    logic [31:0] w;
    run_op(mk(7'h02, 5'd1, 5'd2, 5'd3, 5'd4), 64'd2, 64'd3, 64'd4, 0, "R1 illegal 02");
    run_op(mk(7'h45, 5'd1, 5'd2, 5'd3, 5'd4), 64'd2, 64'd3, 64'd4, 0, "R1 illegal 45");
    run_op(mk(7'h4D, 5'd1, 5'd2, 5'd3, 5'd4), 64'd2, 64'd3, 64'd4, 0, "R1 illegal 4D");
    run_op(mk(7'h60, 5'd1, 5'd2, 5'd3, 5'd4), 64'd2, 64'd3, 64'd4, 0, "R1 illegal 60");
    w = mk(7'h40, 5'd1, 5'd2, 5'd3, 5'd4);
    w[28:24] = 5'b11010;
    run_op(w, 64'd2, 64'd3, 64'd4, 0, "R1 bad group");
  endtask

  task automatic t_backpressure;
    run_op(mk(7'h4A, 5'd9, 5'd2, 5'd3, 5'd4), 64'h0000_0000_FFFF_0000,
           64'h0000_0000_0001_FFFF, 64'h42, 5, "R10 stall");
    run_op(mk(7'h45, 5'd9, 5'd2, 5'd3, 5'd4), 64'd1, 64'd1, 64'd1, 3, "R10 stall illegal");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_madd64();
    t_32bit();
    t_widen();
    t_high();
    t_zero_reg();
    t_illegal();
    t_backpressure();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule